// File: doc/BRIEF.md
# Nibble-packing dual-clock FIFO

This block carries a gated stream of 4-bit values from a fast write clock into a slower, unrelated read clock, where it is consumed one byte at a time. On every write-clock edge where the gate input is high and the write side is not full, the nibble on the input is taken. Two taken nibbles are packed into one byte, and only the completed byte is committed to storage. A nibble left alone when the gate drops stays in the packer until its partner arrives.

The read side pops one byte per read-clock edge when a request is present and the FIFO is not empty. The byte appears on the output register one read-clock cycle later. Each domain has its own flag (full on the write side, empty on the read side) and its own occupancy count in bytes. These are derived from pointers that cross between the clocks as Gray code through a chain of synchronising flops, so both flags err on the safe side. One asynchronous clear input returns both domains to the empty state.

Top module: `nibble_pack_fifo`

## Requirements
- R1: The first nibble taken after clear lands in bits [3:0] of a byte and the second in bits [7:4]; bytes leave the read port in the order in which they were completed.
- R2: A nibble is taken only on a write-clock edge where the gate input is 1 and the full output is 0; on any other edge the input nibble has no effect on the stored data.
- R3: A single taken nibble with no partner yet is invisible to the read side: the empty output stays 1 and both counts stay 0 until the second nibble is taken.
- R4: The full output is 1 exactly when DEPTH bytes (16 by default) are held from the write side's view; nibbles offered while it is 1 are refused and never reach the packer.
- R5: A read request while the empty output is 1 is ignored: no byte is consumed and the data output keeps its value.
- R6: A byte popped on a read-clock edge is on the data output right after that edge and stays there until the next accepted pop.
- R7: The write-side and read-side counts give the number of stored bytes (0 to DEPTH) and agree once both domains have seen each other's latest pointer.
- R8: Pointers cross between domains in Gray code, changing by at most one bit per source-clock cycle, so the far side's counts settle to the exact value.
- R9: Asserting the clear input empties the FIFO, zeroes both counts, discards a held lone nibble and sets the data output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| clr_async | input | 1 | Asynchronous clear, active high, for both domains |
| wr_gate | input | 1 | Admits the input nibble on this edge when high |
| wr_nib | input | 4 | Input nibble |
| wr_full | output | 1 | No room for another byte |
| wr_count | output | 5 | Stored bytes, write-side view |
| rd_req | input | 1 | Read request |
| rd_data | output | 8 | Last popped byte (registered) |
| rd_empty | output | 1 | No byte available |
| rd_count | output | 5 | Stored bytes, read-side view |

## Verification
A vector table of nibble pairs tries the packing with distinct low and high halves, with all-ones against all-zeros halves and with equal halves, so a swapped or duplicated half shows as a wrong byte. Bursts with the gate low and a changing nibble show whether ungated data leaks into the packer. A lone nibble followed by a clear, and a fill to capacity followed by extra offered nibbles, tell refused input apart from input that was taken and lost. Reads while empty followed by one fresh byte show whether the read pointer slipped.

// File: rtl/nbf_pkg.sv
package nbf_pkg;

   localparam int unsigned NBF_MIN_SYNC = 2;

   function automatic bit nbf_is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/nbf_gray_xing.sv
module nbf_gray_xing #(
   parameter int unsigned PW     = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic          src_clk,
   input  logic          dst_clk,
   input  logic          rst,
   input  logic [PW-1:0] src_bin,
   output logic [PW-1:0] dst_bin
);

   logic [PW-1:0] src_gray;
   logic [PW-1:0] chain [STAGES];

   always_ff @(posedge src_clk or posedge rst) begin
      if (rst) src_gray <= '0;
      else     src_gray <= src_bin ^ (src_bin >> 1);
   end

   always_ff @(posedge dst_clk or posedge rst) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= src_gray;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   always_comb begin
      logic [PW-1:0] b;
      b[PW-1] = chain[STAGES-1][PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ chain[STAGES-1][i];
      dst_bin = b;
   end

   // R8: the crossing word changes in at most one bit per source cycle
   assert_gray_one_step_R8: assert property (@(posedge src_clk) disable iff (rst)
      $countones(src_gray ^ $past(src_gray)) <= 1);

endmodule

// File: rtl/nbf_packer.sv
module nbf_packer #(
   parameter int unsigned NIB_W = 4,
   parameter int unsigned LANES = 2,
   localparam int unsigned LW     = (LANES > 1) ? $clog2(LANES) : 1,
   localparam int unsigned WORD_W = NIB_W * LANES
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              take_i,
   input  logic [NIB_W-1:0]  nib_i,
   output logic              word_valid_o,
   output logic [WORD_W-1:0] word_o
);

   localparam logic [LW-1:0] LAST = LW'(LANES - 1);

   logic [LW-1:0]                 lane_idx;
   logic [LANES-2:0][NIB_W-1:0]   held;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         lane_idx <= '0;
         held     <= '0;
      end else if (take_i) begin
         if (lane_idx == LAST) lane_idx <= '0;
         else                  lane_idx <= lane_idx + 1'b1;
         for (int k = 0; k < LANES - 1; k++) begin
            if (lane_idx == LW'(k)) held[k] <= nib_i;
         end
      end
   end

   // the incoming nibble completes the word; earlier lanes sit below it
   assign word_valid_o = take_i && (lane_idx == LAST);
   assign word_o       = {nib_i, held};

   // R3: a partial word leaves the lane counter away from zero
   assert_partial_pending_R3: assert property (@(posedge clk) disable iff (rst)
      (take_i && lane_idx != LAST) |=> (lane_idx != '0));

endmodule

// File: rtl/nbf_dpram.sv
module nbf_dpram #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          wr_clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic          rd_clk,
   input  logic          rst,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge rd_clk or posedge rst) begin
      if (rst)     rdata <= '0;
      else if (re) rdata <= mem[raddr];
   end

endmodule

// File: rtl/nibble_pack_fifo.sv
module nibble_pack_fifo
   import nbf_pkg::*;
#(
   parameter int unsigned NIB_W       = 4,
   parameter int unsigned LANES       = 2,
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned WORD_W = NIB_W * LANES,
   localparam int unsigned AW     = $clog2(DEPTH),
   localparam int unsigned PW     = AW + 1
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              clr_async,
   input  logic              wr_gate,
   input  logic [NIB_W-1:0]  wr_nib,
   output logic              wr_full,
   output logic [PW-1:0]     wr_count,
   input  logic              rd_req,
   output logic [WORD_W-1:0] rd_data,
   output logic              rd_empty,
   output logic [PW-1:0]     rd_count
);

   // elaboration-time parameter checks
   if (!nbf_is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (LANES < 2) begin : g_bad_lanes
      $error("LANES must be at least 2");
   end
   if (SYNC_STAGES < NBF_MIN_SYNC) begin : g_bad_sync
      $error("SYNC_STAGES below the minimum");
   end

   // ---------------- write domain ----------------
   logic              take;
   logic              commit;
   logic [WORD_W-1:0] packed_word;
   logic [PW-1:0]     wr_ptr;
   logic [PW-1:0]     rd_ptr_at_w;

   assign take = wr_gate && !wr_full;

   nbf_packer #(.NIB_W(NIB_W), .LANES(LANES)) u_pack (
      .clk          (wr_clk),
      .rst          (clr_async),
      .take_i       (take),
      .nib_i        (wr_nib),
      .word_valid_o (commit),
      .word_o       (packed_word)
   );

   always_ff @(posedge wr_clk or posedge clr_async) begin
      if (clr_async)   wr_ptr <= '0;
      else if (commit) wr_ptr <= wr_ptr + 1'b1;
   end

   assign wr_full  = (wr_ptr[AW] != rd_ptr_at_w[AW]) &&
                     (wr_ptr[AW-1:0] == rd_ptr_at_w[AW-1:0]);
   assign wr_count = wr_ptr - rd_ptr_at_w;

   // R4: nothing commits while full
   assert_full_holds_ptr_R4: assert property (@(posedge wr_clk) disable iff (clr_async)
      wr_full |=> $stable(wr_ptr));
   // R7: write-side occupancy never exceeds the depth
   assert_wcount_bound_R7: assert property (@(posedge wr_clk) disable iff (clr_async)
      wr_count <= PW'(DEPTH));

   // ---------------- read domain ----------------
   logic          pop;
   logic [PW-1:0] rd_ptr;
   logic [PW-1:0] wr_ptr_at_r;

   assign rd_empty = (rd_ptr == wr_ptr_at_r);
   assign rd_count = wr_ptr_at_r - rd_ptr;
   assign pop      = rd_req && !rd_empty;

   always_ff @(posedge rd_clk or posedge clr_async) begin
      if (clr_async) rd_ptr <= '0;
      else if (pop)  rd_ptr <= rd_ptr + 1'b1;
   end

   // R5: the read pointer never moves while empty
   assert_no_underflow_R5: assert property (@(posedge rd_clk) disable iff (clr_async)
      rd_empty |=> $stable(rd_ptr));
   // R7: read-side occupancy never exceeds the depth
   assert_rcount_bound_R7: assert property (@(posedge rd_clk) disable iff (clr_async)
      rd_count <= PW'(DEPTH));

   // ---------------- storage and crossings ----------------
   nbf_dpram #(.W(WORD_W), .DEPTH(DEPTH)) u_ram (
      .wr_clk (wr_clk),
      .we     (commit),
      .waddr  (wr_ptr[AW-1:0]),
      .wdata  (packed_word),
      .rd_clk (rd_clk),
      .rst    (clr_async),
      .re     (pop),
      .raddr  (rd_ptr[AW-1:0]),
      .rdata  (rd_data)
   );

   nbf_gray_xing #(.PW(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .src_clk (wr_clk),
      .dst_clk (rd_clk),
      .rst     (clr_async),
      .src_bin (wr_ptr),
      .dst_bin (wr_ptr_at_r)
   );

   nbf_gray_xing #(.PW(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .src_clk (rd_clk),
      .dst_clk (wr_clk),
      .rst     (clr_async),
      .src_bin (rd_ptr),
      .dst_bin (rd_ptr_at_w)
   );

endmodule

// File: tb/nibble_pack_fifo_test.sv
module nibble_pack_fifo_test;

   logic       wr_clk = 1'b0;
   logic       rd_clk = 1'b0;
   logic       clr_async = 1'b1;
   logic       wr_gate = 1'b0;
   logic [3:0] wr_nib = 4'h0;
   logic       rd_req = 1'b0;
   logic       wr_full, rd_empty;
   logic [4:0] wr_count, rd_count;
   logic [7:0] rd_data;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 wr_clk = ~wr_clk;   // fast write clock
   always #5 rd_clk = ~rd_clk;   // 100 MHz read clock

   nibble_pack_fifo uut (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .clr_async(clr_async),
      .wr_gate(wr_gate), .wr_nib(wr_nib), .wr_full(wr_full), .wr_count(wr_count),
      .rd_req(rd_req), .rd_data(rd_data), .rd_empty(rd_empty), .rd_count(rd_count)
   );

   // {low nibble, high nibble, expected byte}
   localparam logic [15:0] VEC [8] = '{
      16'h1_2_21, 16'hA_5_5A, 16'hF_0_0F, 16'h0_F_F0,
      16'h3_C_C3, 16'h8_8_88, 16'h7_E_E7, 16'h0_0_00
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push_nib(input logic [3:0] n);
      @(negedge wr_clk);
      wr_gate = 1'b1;
      wr_nib  = n;
      @(negedge wr_clk);
      wr_gate = 1'b0;
   endtask

   task automatic pop(output logic [7:0] v);
      @(negedge rd_clk);
      rd_req = 1'b1;
      @(negedge rd_clk);
      rd_req = 1'b0;
      v = rd_data;
   endtask

   task automatic settle();
      repeat (8) @(negedge rd_clk);
   endtask

   task automatic do_clear();
      @(negedge wr_clk);
      clr_async = 1'b1;
      #3;
      clr_async = 1'b0;
      settle();
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge rd_clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      logic [7:0] v;
      logic [7:0] held;
      #7;
      clr_async = 1'b0;
      settle();

      // R9: state after clear
      @(negedge wr_clk);
      check("R9 wr_full after clear", wr_full, 0);
      check("R9 wr_count after clear", wr_count, 0);
      @(negedge rd_clk);
      check("R9 rd_empty after clear", rd_empty, 1);
      check("R9 rd_count after clear", rd_count, 0);
      check("R9 rd_data after clear", rd_data, 0);

      // R1: vector table of nibble pairs
      for (int i = 0; i < 8; i++) begin
         push_nib(VEC[i][15:12]);
         push_nib(VEC[i][11:8]);
      end
      settle();
      check("R7 rd_count after table", rd_count, 8);
      @(negedge wr_clk);
      check("R7 wr_count after table", wr_count, 8);
      for (int i = 0; i < 8; i++) begin
         pop(v);
         check("R1 table byte", v, VEC[i][7:0]);
      end
      check("R5 empty after draining table", rd_empty, 1);
      settle();
      @(negedge wr_clk);
      check("R8 wr_count settles after reads", wr_count, 0);

      // R6: output holds after an idle cycle
      repeat (2) @(negedge rd_clk);
      check("R6 rd_data held while idle", rd_data, 8'h00);

      // R3: lone nibble stays hidden
      push_nib(4'hB);
      settle();
      check("R3 empty with lone nibble", rd_empty, 1);
      check("R3 rd_count with lone nibble", rd_count, 0);
      @(negedge wr_clk);
      check("R3 wr_count with lone nibble", wr_count, 0);
      push_nib(4'h4);
      settle();
      check("R3 rd_count after partner", rd_count, 1);
      pop(v);
      check("R3 R1 byte from split pair", v, 8'h4B);
      held = v;
      repeat (3) @(negedge rd_clk);
      check("R6 rd_data stable after pop", rd_data, held);

      // R5: reads while empty are ignored
      for (int i = 0; i < 3; i++) begin
         pop(v);
         check("R5 rd_data unchanged on empty read", v, held);
      end
      check("R5 rd_count on empty read", rd_count, 0);

      // R2: gate low with a changing nibble
      for (int i = 0; i < 6; i++) begin
         @(negedge wr_clk);
         wr_nib = 4'(i + 1);
      end
      settle();
      check("R2 nothing stored with gate low", rd_count, 0);
      push_nib(4'h6);
      for (int i = 0; i < 5; i++) begin
         @(negedge wr_clk);
         wr_nib = 4'(i + 8);
      end
      push_nib(4'h9);
      settle();
      pop(v);
      check("R2 R5 byte after gated burst", v, 8'h96);
      settle();

      // R4: fill to capacity, then offer more
      for (int k = 0; k < 16; k++) begin
         push_nib(4'(k));
         push_nib(4'(15 - k));
      end
      @(negedge wr_clk);
      check("R4 wr_full at depth", wr_full, 1);
      check("R4 wr_count at depth", wr_count, 16);
      for (int i = 0; i < 4; i++) push_nib(4'hD);
      settle();
      check("R4 R7 rd_count at depth", rd_count, 16);
      for (int k = 0; k < 16; k++) begin
         pop(v);
         check("R4 R1 byte from full buffer", v, {4'(15 - k), 4'(k)});
      end
      check("R5 empty after draining full buffer", rd_empty, 1);
      settle();
      @(negedge wr_clk);
      check("R4 wr_full clears after drain", wr_full, 0);
      push_nib(4'h2);
      push_nib(4'h7);
      settle();
      pop(v);
      check("R4 refused nibbles left packer clean", v, 8'h72);

      // R9: clear discards stored bytes and a lone nibble
      push_nib(4'h1);
      push_nib(4'h3);
      push_nib(4'h5);
      settle();
      do_clear();
      check("R9 rd_empty after mid-run clear", rd_empty, 1);
      check("R9 rd_data zero after clear", rd_data, 0);
      @(negedge wr_clk);
      check("R9 wr_count after mid-run clear", wr_count, 0);
      push_nib(4'hC);
      push_nib(4'hE);
      settle();
      check("R9 rd_count after fresh pair", rd_count, 1);
      pop(v);
      check("R9 lone nibble discarded by clear", v, 8'hEC);

      done = 1'b1;
      finish_run();
   end

endmodule